// File: doc/BRIEF.md
# Audio Transmit Serializer

The block takes parallel left and right audio samples and shifts them out MSB first on one serial data line. Timing comes from one of two clock units. Each unit supplies two signals in the system clock domain. The first is a one-cycle strobe marking a falling bit-clock edge. The second is a frame-select level. The serial output changes only on strobes of the selected unit, so a receiver can sample it on the following rising bit-clock edge.

A frame has a left slot, where the effective frame select is low, and a right slot, where it is high. A new stereo pair is requested through a valid/ready handshake at the start of each frame. If no pair is offered, the frame is sent as zeros and an underrun flag is raised. Several settings control the slot contents:

- the sample word size
- the slot size
- left or right placement of the sample within the slot
- a mono mode that repeats the left sample
- a zero-bit or one-bit delay after each frame-select transition

Top module: `audio_tx_serializer`

## Requirements
- R1: On each strobe of the selected unit, `sd_o` takes the next slot bit at the following clock edge, MSB first, and holds it until the next such strobe. The effective frame select low selects the left slot and high selects the right slot.
- R2: With `delay_i`=0, the first bit of a slot is sent on the strobe where the new frame-select level is first seen. With `delay_i`=1, the effective frame select is the level seen one strobe earlier, so every slot starts one bit period later.
- R3: `word_sel_i` gives the sample width: 0=8, 1=16, 2=18, 3=20, 4=24, 5..7=32. Samples arrive right-aligned in `left_i`/`right_i`, and bits above the word width are ignored.
- R4: `slot_sel_i` gives the slot width: 0=8, 1=16, 2=24, 3=32. Slot bits not holding sample bits are sent as 0, and so are positions past the slot width when the frame select stays longer.
- R5: With `right_adj_i`=0, the sample starts at slot position 0. With `right_adj_i`=1, it ends at the last slot position.
- R6: With `mono_i`=1, the right slot carries the left sample of the same pair.
- R7: If the word width exceeds the slot width, only the slot-width most significant sample bits are sent.
- R8: `ready_o` is high only during the cycle of a selected strobe that starts a left slot. A pair is taken when `valid_i` is also high in that cycle.
- R9: If `valid_i` is low at a frame start, that frame is sent as zeros and `underrun_o` is high from the next cycle. A frame start with `valid_i` high clears it at the next cycle, and otherwise it holds.
- R10: `cu_sel_i` picks the clock unit. Strobes and frame-select levels of the other unit have no effect.
- R11: After reset, `sd_o`=0, `underrun_o`=0, and `ready_o` stays low until the first frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cu_sel_i | input | CU_W | Clock unit select |
| bclk_fall_i | input | N_CU | Per-unit falling bit-clock strobe |
| fs_i | input | N_CU | Per-unit frame-select level |
| word_sel_i | input | 3 | Word size code |
| slot_sel_i | input | 2 | Slot size code |
| right_adj_i | input | 1 | Right-adjust sample within slot |
| mono_i | input | 1 | Repeat left sample in right slot |
| delay_i | input | 1 | One-bit data delay after frame select |
| valid_i | input | 1 | Sample pair valid |
| left_i | input | DW | Left sample, right-aligned |
| right_i | input | DW | Right sample, right-aligned |
| ready_o | output | 1 | Sample pair accepted this cycle |
| sd_o | output | 1 | Serial data |
| underrun_o | output | 1 | Current frame had no sample pair |

## Verification
`ready_o` depends combinationally on the strobe cycle. The bench drives each strobe just after a falling clock edge and reads `ready_o` one time step later, in the same cycle. `sd_o` and `underrun_o` are registered once and are due at the clock edge that samples the strobe. The bench reads them at the next falling edge. `sd_o` is then read again after a cycle in which only the unselected unit strobes, with random frame select, to show the value held. Expected bits come from a frame-position formula per bit. The sweep covers every word size, slot size, adjustment, delay and mono combination, on alternating clock units, with and without over-long slots and a missing pair.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;
  localparam int POS_W = 6;

  function automatic logic [5:0] word_bits(input logic [2:0] sel);
    case (sel)
      3'd0:    return 6'd8;
      3'd1:    return 6'd16;
      3'd2:    return 6'd18;
      3'd3:    return 6'd20;
      3'd4:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic [5:0] slot_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    return 6'd8;
      2'd1:    return 6'd16;
      2'd2:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction
endpackage

// File: rtl/tx_cu_select.sv
module tx_cu_select #(
  parameter int N_CU = 2,
  parameter int CU_W = 1
) (
  input  logic [CU_W-1:0] sel_i,
  input  logic [N_CU-1:0] strb_i,
  input  logic [N_CU-1:0] fs_i,
  output logic            strb_o,
  output logic            fs_o
);
  always_comb begin
    strb_o = 1'b0;
    fs_o   = 1'b0;
    for (int i = 0; i < N_CU; i++) begin
      if (sel_i == CU_W'(i)) begin
        strb_o = strb_i[i];
        fs_o   = fs_i[i];
      end
    end
  end
endmodule

// File: rtl/tx_frame_track.sv
module tx_frame_track #(
  parameter int POS_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strb_i,
  input  logic             fs_i,
  input  logic             delay_i,
  output logic             slot_start_o,
  output logic             chan_o,
  output logic [POS_W-1:0] pos_o
);
  logic             fs_d_q, fs_dd_q;
  logic             cur_fs, prev_fs;
  logic [POS_W-1:0] pos_q;

  // delayed format shifts the effective frame select by one strobe
  assign cur_fs       = delay_i ? fs_d_q  : fs_i;
  assign prev_fs      = delay_i ? fs_dd_q : fs_d_q;
  assign slot_start_o = cur_fs != prev_fs;
  assign chan_o       = cur_fs;

  always_comb begin
    if (slot_start_o)      pos_o = '0;
    else if (&pos_q)       pos_o = pos_q;
    else                   pos_o = pos_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_d_q  <= 1'b1;
      fs_dd_q <= 1'b1;
      pos_q   <= '1;
    end else if (strb_i) begin
      fs_d_q  <= fs_i;
      fs_dd_q <= fs_d_q;
      pos_q   <= pos_o;
    end
  end
endmodule

// File: rtl/tx_bit_pick.sv
module tx_bit_pick #(
  parameter int DW    = 32,
  parameter int POS_W = 6
) (
  input  logic [DW-1:0]    sample_i,
  input  logic [2:0]       word_sel_i,
  input  logic [1:0]       slot_sel_i,
  input  logic             right_adj_i,
  input  logic [POS_W-1:0] pos_i,
  output logic             bit_o
);
  import audio_tx_pkg::*;
  localparam int IW = $clog2(DW);

  logic [6:0] w, s, e, pad, pos, rel, idx;
  logic       in_rng;

  always_comb begin
    w   = {1'b0, word_bits(word_sel_i)};
    s   = {1'b0, slot_bits(slot_sel_i)};
    e   = (w < s) ? w : s;            // truncate: keep MSBs
    pad = right_adj_i ? (s - e) : 7'd0;
    pos = 7'(pos_i);
    rel = pos - pad;
    idx = w - 7'd1 - rel;
    in_rng = (pos >= pad) && (pos < pad + e);
    bit_o  = in_rng ? sample_i[idx[IW-1:0]] : 1'b0;
  end
endmodule

// File: rtl/audio_tx_serializer.sv
module audio_tx_serializer #(
  parameter int DW   = 32,
  parameter int N_CU = 2,
  localparam int CU_W = (N_CU > 1) ? $clog2(N_CU) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CU_W-1:0] cu_sel_i,
  input  logic [N_CU-1:0] bclk_fall_i,
  input  logic [N_CU-1:0] fs_i,
  input  logic [2:0]      word_sel_i,
  input  logic [1:0]      slot_sel_i,
  input  logic            right_adj_i,
  input  logic            mono_i,
  input  logic            delay_i,
  input  logic            valid_i,
  input  logic [DW-1:0]   left_i,
  input  logic [DW-1:0]   right_i,
  output logic            ready_o,
  output logic            sd_o,
  output logic            underrun_o
);
  import audio_tx_pkg::*;

  logic             strb, fs, slot_start, chan, frame_start, nxt_bit;
  logic [POS_W-1:0] pos;
  logic [DW-1:0]    left_q, right_q, cur_l, cur_r, cur_s;
  logic             sd_q, underrun_q;

  tx_cu_select #(.N_CU(N_CU), .CU_W(CU_W)) u_cu (
    .sel_i (cu_sel_i),
    .strb_i(bclk_fall_i),
    .fs_i  (fs_i),
    .strb_o(strb),
    .fs_o  (fs)
  );

  tx_frame_track #(.POS_W(POS_W)) u_trk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strb_i      (strb),
    .fs_i        (fs),
    .delay_i     (delay_i),
    .slot_start_o(slot_start),
    .chan_o      (chan),
    .pos_o       (pos)
  );

  assign frame_start = strb && slot_start && !chan;
  assign ready_o     = frame_start;

  // first bit of a frame uses the pair being accepted now
  always_comb begin
    if (frame_start) begin
      cur_l = valid_i ? left_i  : '0;
      cur_r = valid_i ? right_i : '0;
    end else begin
      cur_l = left_q;
      cur_r = right_q;
    end
    cur_s = (chan && !mono_i) ? cur_r : cur_l;
  end

  tx_bit_pick #(.DW(DW), .POS_W(POS_W)) u_pick (
    .sample_i   (cur_s),
    .word_sel_i (word_sel_i),
    .slot_sel_i (slot_sel_i),
    .right_adj_i(right_adj_i),
    .pos_i      (pos),
    .bit_o      (nxt_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q     <= '0;
      right_q    <= '0;
      underrun_q <= 1'b0;
      sd_q       <= 1'b0;
    end else if (strb) begin
      sd_q <= nxt_bit;
      if (frame_start) begin
        left_q     <= cur_l;
        right_q    <= cur_r;
        underrun_q <= !valid_i;
      end
    end
  end

  assign sd_o       = sd_q;
  assign underrun_o = underrun_q;
endmodule

// File: rtl/audio_tx_serializer_chk.sv
module audio_tx_serializer_chk #(
  parameter int DW   = 32,
  parameter int N_CU = 2,
  localparam int CU_W = (N_CU > 1) ? $clog2(N_CU) : 1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [CU_W-1:0] cu_sel_i,
  input logic [N_CU-1:0] bclk_fall_i,
  input logic            valid_i,
  input logic            ready_o,
  input logic            sd_o,
  input logic            underrun_o
);
  a_r8_ready_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> bclk_fall_i[cu_sel_i]);

  a_r1_hold_between_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bclk_fall_i[cu_sel_i] |=> $stable(sd_o));

  a_r9_underrun_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !valid_i) |=> underrun_o);

  a_r9_underrun_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && valid_i) |=> !underrun_o);

  a_r9_underrun_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> $stable(underrun_o));
endmodule

bind audio_tx_serializer audio_tx_serializer_chk #(.DW(DW), .N_CU(N_CU)) u_chk (.*);

// File: tb/sim_audio_tx_serializer.sv
module sim_audio_tx_serializer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [0:0]  cu_sel;
  logic [1:0]  bclk, fs;
  logic [2:0]  word_sel;
  logic [1:0]  slot_sel;
  logic        radj, mono, dly, valid;
  logic [31:0] left, right;
  logic        ready, sd, ur;
  int          checks = 0, fails = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  audio_tx_serializer u0 (
    .clk_i(clk), .rst_ni(rst_n), .cu_sel_i(cu_sel), .bclk_fall_i(bclk), .fs_i(fs),
    .word_sel_i(word_sel), .slot_sel_i(slot_sel), .right_adj_i(radj), .mono_i(mono),
    .delay_i(dly), .valid_i(valid), .left_i(left), .right_i(right),
    .ready_o(ready), .sd_o(sd), .underrun_o(ur)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int wbits(input int sel);
    case (sel) 0: return 8; 1: return 16; 2: return 18; 3: return 20; 4: return 24; default: return 32; endcase
  endfunction

  function automatic bit exp_bit(input logic [31:0] s, input int w, input int sl, input bit adj, input int k);
    int e, pad;
    e   = (w < sl) ? w : sl;
    pad = adj ? sl - e : 0;
    if (k < pad || k >= pad + e) return 1'b0;
    return s[w - 1 - (k - pad)];
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lv[3], rv[3];
    bit          und[3];
    bit          exp_ur;
    rst_n = 1'b0; bclk = '0; fs = '0; valid = 0; left = '0; right = '0;
    cu_sel = '0; word_sel = '0; slot_sel = '0; radj = 0; mono = 0; dly = 0;
    for (int idx = 0; idx < 192; idx++) begin
      int ws, ss, w, sl, f, cu;
      ws = idx % 6; ss = (idx / 6) % 4;
      w = wbits(ws); sl = 8 * (ss + 1);
      f = sl + ((idx % 3 == 2) ? 3 : 0);
      cu = idx % 2;
      for (int i = 0; i < 3; i++) begin
        lv[i] = $urandom; rv[i] = $urandom;
        und[i] = (idx % 4 == 1) && (i == 1);
      end
      @(negedge clk);
      rst_n = 1'b0; bclk = '0;
      word_sel = 3'(ws); slot_sel = 2'(ss); radj = (idx / 24) % 2 == 1;
      dly = (idx / 48) % 2 == 1; mono = (idx / 96) % 2 == 1; cu_sel = 1'(cu);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state
      chk(sd == 1'b0, "R11 sd", sd, 0);
      chk(ur == 1'b0, "R11 underrun", ur, 0);
      chk(ready == 1'b0, "R11 ready", ready, 0);
      exp_ur = 0;
      for (int g = 0; g < 6 * f + int'(dly); g++) begin
        int gp, fr, b, bp, k;
        bit fsv, exp_rdy, ch, e;
        logic [31:0] smp;
        string tag;
        gp = g - int'(dly);
        fr = (gp >= 0) ? gp / (2 * f) : 0;
        if (fr > 2) fr = 2;
        b = g % (2 * f);
        fsv = b >= f;
        bclk = '0; bclk[cu] = 1'b1;
        fs[cu] = fsv; fs[1 - cu] = 1'($urandom);
        valid = !und[fr]; left = lv[fr]; right = rv[fr];
        #1;
        exp_rdy = (gp >= 0) && (gp % (2 * f) == 0);
        chk(ready == exp_rdy, "R8 ready", ready, exp_rdy);
        if (exp_rdy) exp_ur = und[fr];
        @(posedge clk);
        @(negedge clk);
        if (gp < 0) begin
          e = 0; tag = "R2";
        end else begin
          bp = gp % (2 * f);
          ch = bp >= f;
          k = ch ? bp - f : bp;
          smp = und[fr] ? 32'd0 : ((ch && !mono) ? rv[fr] : lv[fr]);
          e = exp_bit(smp, w, sl, radj, k);
          if (und[fr])          tag = "R9";
          else if (k >= sl)     tag = "R4";
          else if (w > sl)      tag = "R7";
          else if (mono && ch)  tag = "R6";
          else if (radj)        tag = "R5";
          else if (dly)         tag = "R2";
          else if (ws != 5)     tag = "R3";
          else                  tag = "R1";
        end
        chk(sd == e, tag, sd, e);
        chk(ur == exp_ur, "R9 underrun", ur, exp_ur);
        // only the other unit strobes now
        bclk = '0; bclk[1 - cu] = 1'b1; fs[1 - cu] = 1'($urandom);
        @(posedge clk);
        @(negedge clk);
        chk(sd == e, "R10 other unit", sd, e);
        bclk = '0;
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule